// File: doc/BRIEF.md
# Per-Hop Ring Event Status with Read-Clear and Sweep Re-Arm

This block gathers three kinds of per-hop ring events (transmit complete, receive complete, receive overflow) into a packed status bank. A host reaches the bank through a simple 32-bit word-addressed register port. Each event kind takes one contiguous field of `HOPS` bits. The fields follow one another, so a field may straddle a 32-bit word boundary. Reading a status word hands its contents to the host and, in the default mode, clears it.

A bank of enable bits selects which hops may raise the single interrupt line. Each hop has one receive enable and one transmit enable. An overflow on a hop is gated by that hop's receive enable. Once the interrupt has been raised, it stays suppressed after servicing begins until the host has read every status word, including words whose bits are all disabled. A control bit turns off read-clear. Status is then cleared by writing ones instead. A read-only register reports the hop count.

Top module: `ring_notify`

## Requirements
- R1: Status bit index is f*HOPS+h, where f=0 is transmit, f=1 is receive and f=2 is overflow for hop h. The bit sits in status word index/32 at bit index%32. The status words occupy word addresses 0 to (31+3*HOPS)/32-1.
- R2: A read presents its data on `rdata` and raises `rvalid` in the cycle after `rd_en` is sampled. `rvalid` is low in every other cycle.
- R3: With read-clear on, a read returns the word and clears it. An event that arrives in the same cycle as the read is absent from the returned data and is still set afterwards.
- R4: The enable words start at word address 0x10, with (31+2*HOPS)/32 words. Receive enable for hop h is bit h and transmit enable is bit HOPS+h. The words are read/write, bits at or above 2*HOPS read 0, and all enables reset to 0.
- R5: `irq` is high exactly when the block is armed and a status bit is set whose enable is on. Overflow uses the receive enable of its hop. Events whose enable is off leave `irq` low.
- R6: A status read while `irq` is high disarms the block, which drives `irq` low. The block re-arms only once every status word has been read since that read began servicing. Disabled-only words count, and repeat reads of one word do not substitute for the others.
- R7: Word address 0x20 reads the hop count in bits 10:0, with zeros above. Writes to it have no effect.
- R8: Control word 0x21 bit 2 enables read-clear and resets to 1. When it is 0, reads leave status unchanged and a write to a status word clears the bits written as 1. When it is 1, writes to status words are ignored.
- R9: After reset, all status bits are 0, `irq` is low, the block is armed and the control word reads 0x4.
- R10: Addresses outside the status words, enable words, 0x20 and 0x21 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_tx | input | HOPS | Transmit-complete event per hop, one-cycle pulses |
| ev_rx | input | HOPS | Receive-complete event per hop |
| ev_ovf | input | HOPS | Receive-overflow event per hop |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe, ignored when `rd_en` is high |
| addr | input | ADDR_W | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| rvalid | output | 1 | Read data valid, one cycle after `rd_en` |
| irq | output | 1 | Level interrupt |

## Verification
The assertions watch the timing of the read port on every cycle, along with several properties of the interrupt state. `irq` never rises while disarmed, the disarmed state cannot end without a read, the hop-count word reads back correctly, and an event on hop 0 always lands in status. Only the bench's scenarios can show the packing of every hop and field across the word boundary. They also exercise the exact sweep order that re-arms the interrupt, the overflow-through-receive-enable gating, and the loss-free event during a clearing read. The write-one-to-clear mode is covered the same way.

// File: rtl/ring_notify_pkg.sv
package ring_notify_pkg;
  localparam int DW          = 32;
  localparam int EN_BASE     = 'h10;
  localparam int HOPCNT_ADDR = 'h20;
  localparam int CTRL_ADDR   = 'h21;
  localparam int RDCLR_BIT   = 2;
  localparam int HOPCNT_BITS = 11;

  function automatic int stat_words(input int hops);
    return (31 + 3 * hops) / 32;
  endfunction

  function automatic int en_words(input int hops);
    return (31 + 2 * hops) / 32;
  endfunction
endpackage

// File: rtl/ring_notify_status.sv
module ring_notify_status import ring_notify_pkg::*; #(
  parameter int HOPS = 12,
  parameter int NSW  = 2,
  parameter int WIW  = 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [HOPS-1:0]     ev_tx,
  input  logic [HOPS-1:0]     ev_rx,
  input  logic [HOPS-1:0]     ev_ovf,
  input  logic                rd_hit,
  input  logic                wr_hit,
  input  logic [WIW-1:0]      idx,
  input  logic [DW-1:0]       wdata,
  input  logic                rd_clear,
  output logic [NSW*DW-1:0]   stat_q,
  output logic [NSW*DW-1:0]   stat_n
);
  localparam int SBITS = NSW * DW;

  logic [SBITS-1:0] ev_vec;
  logic [SBITS-1:0] clr;

  always_comb begin
    ev_vec = '0;
    ev_vec[HOPS-1:0]        = ev_tx;
    ev_vec[2*HOPS-1:HOPS]   = ev_rx;
    ev_vec[3*HOPS-1:2*HOPS] = ev_ovf;
  end

  for (genvar w = 0; w < NSW; w++) begin : g_word
    logic sel;
    assign sel = (idx == WIW'(w));
    always_comb begin
      if (rd_hit && rd_clear && sel)
        clr[w*DW +: DW] = '1;
      else if (wr_hit && !rd_clear && sel)
        clr[w*DW +: DW] = wdata;
      else
        clr[w*DW +: DW] = '0;
    end
  end

  // clear first, then merge new events so a same-cycle event survives
  assign stat_n = (stat_q & ~clr) | ev_vec;

  always_ff @(posedge clk) begin
    if (rst) stat_q <= '0;
    else     stat_q <= stat_n;
  end
endmodule

// File: rtl/ring_notify_cfg.sv
module ring_notify_cfg import ring_notify_pkg::*; #(
  parameter int HOPS = 12,
  parameter int NEW  = 1,
  parameter int EIW  = 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en_wr,
  input  logic [EIW-1:0]      en_idx,
  input  logic                ctl_wr,
  input  logic [DW-1:0]       wdata,
  output logic [NEW*DW-1:0]   en_q,
  output logic                rd_clear
);
  localparam int EBITS = NEW * DW;
  localparam logic [EBITS-1:0] EN_MASK = (EBITS'(1) << (2 * HOPS)) - EBITS'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= '0;
      rd_clear <= 1'b1;
    end else begin
      if (en_wr)
        en_q[en_idx*DW +: DW] <= wdata & EN_MASK[en_idx*DW +: DW];
      if (ctl_wr)
        rd_clear <= wdata[RDCLR_BIT];
    end
  end
endmodule

// File: rtl/ring_notify_arm.sv
module ring_notify_arm #(
  parameter int NSW = 2,
  parameter int WIW = 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           st_rd,
  input  logic [WIW-1:0] idx,
  input  logic           pend_n,
  output logic           armed,
  output logic           irq
);
  localparam logic [NSW-1:0] ALL = '1;

  logic [NSW-1:0] seen, hit, acc, seen_n;
  logic           done, start, armed_n;

  always_comb begin
    hit   = st_rd ? (NSW'(1) << idx) : '0;
    start = armed && irq && st_rd;
    if (start)       acc = hit;
    else if (!armed) acc = seen | hit;
    else             acc = '0;
    done = (acc == ALL);
    if (armed) armed_n = !(start && !done);
    else       armed_n = done;
    seen_n = (done || armed_n) ? '0 : acc;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b1;
      seen  <= '0;
      irq   <= 1'b0;
    end else begin
      armed <= armed_n;
      seen  <= seen_n;
      irq   <= armed_n && pend_n;
    end
  end
endmodule

// File: rtl/ring_notify.sv
module ring_notify import ring_notify_pkg::*; #(
  parameter int HOPS   = 12,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [HOPS-1:0]   ev_tx,
  input  logic [HOPS-1:0]   ev_rx,
  input  logic [HOPS-1:0]   ev_ovf,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              rvalid,
  output logic              irq
);
  localparam int NSW   = stat_words(HOPS);
  localparam int NEW   = en_words(HOPS);
  localparam int SBITS = NSW * DW;
  localparam int EBITS = NEW * DW;
  localparam int WIW   = (NSW > 1) ? $clog2(NSW) : 1;
  localparam int EIW   = (NEW > 1) ? $clog2(NEW) : 1;

  logic             st_sel, en_sel, hop_sel, ctl_sel, wr_ok;
  logic [WIW-1:0]   st_idx;
  logic [EIW-1:0]   en_idx;
  logic [SBITS-1:0] stat_q_w, stat_n_w, enx;
  logic [EBITS-1:0] en_q_w;
  logic             rd_clear_w, pend_n, armed_w;
  logic [DW-1:0]    rd_word;

  assign st_sel  = addr < ADDR_W'(NSW);
  assign en_sel  = (addr >= ADDR_W'(EN_BASE)) && (addr < ADDR_W'(EN_BASE + NEW));
  assign hop_sel = addr == ADDR_W'(HOPCNT_ADDR);
  assign ctl_sel = addr == ADDR_W'(CTRL_ADDR);
  assign st_idx  = WIW'(addr);
  assign en_idx  = EIW'(addr - ADDR_W'(EN_BASE));
  assign wr_ok   = wr_en && !rd_en;

  ring_notify_status #(.HOPS(HOPS), .NSW(NSW), .WIW(WIW)) u_status (
    .clk(clk), .rst(rst),
    .ev_tx(ev_tx), .ev_rx(ev_rx), .ev_ovf(ev_ovf),
    .rd_hit(rd_en && st_sel), .wr_hit(wr_ok && st_sel),
    .idx(st_idx), .wdata(wdata), .rd_clear(rd_clear_w),
    .stat_q(stat_q_w), .stat_n(stat_n_w)
  );

  ring_notify_cfg #(.HOPS(HOPS), .NEW(NEW), .EIW(EIW)) u_cfg (
    .clk(clk), .rst(rst),
    .en_wr(wr_ok && en_sel), .en_idx(en_idx),
    .ctl_wr(wr_ok && ctl_sel), .wdata(wdata),
    .en_q(en_q_w), .rd_clear(rd_clear_w)
  );

  // spread the enables over the status layout; overflow follows receive
  always_comb begin
    enx = '0;
    for (int h = 0; h < HOPS; h++) begin
      enx[h]          = en_q_w[HOPS + h];
      enx[HOPS + h]   = en_q_w[h];
      enx[2*HOPS + h] = en_q_w[h];
    end
  end

  assign pend_n = |(stat_n_w & enx);

  ring_notify_arm #(.NSW(NSW), .WIW(WIW)) u_arm (
    .clk(clk), .rst(rst),
    .st_rd(rd_en && st_sel), .idx(st_idx),
    .pend_n(pend_n), .armed(armed_w), .irq(irq)
  );

  always_comb begin
    if (st_sel)       rd_word = stat_q_w[st_idx*DW +: DW];
    else if (en_sel)  rd_word = en_q_w[en_idx*DW +: DW];
    else if (hop_sel) rd_word = DW'(HOPS) & ((DW'(1) << HOPCNT_BITS) - DW'(1));
    else if (ctl_sel) rd_word = DW'(rd_clear_w) << RDCLR_BIT;
    else              rd_word = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_en;
      if (rd_en) rdata <= rd_word;
    end
  end
endmodule

// File: rtl/ring_notify_chk.sv
module ring_notify_chk import ring_notify_pkg::*; #(
  parameter int HOPS   = 12,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic              rvalid,
  input logic [31:0]       rdata,
  input logic              irq,
  input logic              armed,
  input logic              ev_tx0,
  input logic              stat0
);
  p_rvalid_follows_r2: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rvalid);
  p_rvalid_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rvalid);
  p_event_kept_r3: assert property (@(posedge clk) disable iff (rst)
    ev_tx0 |=> stat0);
  p_quiet_disarmed_r6: assert property (@(posedge clk) disable iff (rst)
    !armed |-> !irq);
  p_stay_disarmed_r6: assert property (@(posedge clk) disable iff (rst)
    (!armed && !rd_en) |=> !armed);
  p_hopcount_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == ADDR_W'(HOPCNT_ADDR)) |=> rdata == 32'(HOPS));
endmodule

bind ring_notify ring_notify_chk #(.HOPS(HOPS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .rd_en(rd_en), .addr(addr),
  .rvalid(rvalid), .rdata(rdata), .irq(irq), .armed(armed_w),
  .ev_tx0(ev_tx[0]), .stat0(stat_q_w[0])
);

// File: tb/ring_notify_bench.sv
`timescale 1ns/1ps
module ring_notify_bench;
  localparam int HOPS = 12;
  localparam int NSW  = (31 + 3 * HOPS) / 32;

  logic clk = 0, rst = 1;
  logic [HOPS-1:0] ev_tx = '0, ev_rx = '0, ev_ovf = '0;
  logic rd_en = 0, wr_en = 0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic rvalid, irq;
  int n_cmp = 0, n_bad = 0;
  logic [31:0] d;

  always #2.5 clk = ~clk;

  ring_notify #(.HOPS(HOPS), .ADDR_W(8)) u_ring_notify (
    .clk(clk), .rst(rst), .ev_tx(ev_tx), .ev_rx(ev_rx), .ev_ovf(ev_ovf),
    .rd_en(rd_en), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rvalid(rvalid), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; v = rdata;
    chk("R2 rvalid", {31'b0, rvalid}, 32'd1);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] v);
    @(negedge clk); wr_en = 1; addr = a; wdata = v;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic pulse(input int f, input int h);
    @(negedge clk);
    if (f == 0) ev_tx[h] = 1; else if (f == 1) ev_rx[h] = 1; else ev_ovf[h] = 1;
    @(negedge clk); ev_tx = '0; ev_rx = '0; ev_ovf = '0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    // R9 reset state
    chk("R9 irq", {31'b0, irq}, 0);
    chk("R2 rvalid idle", {31'b0, rvalid}, 0);
    rd(8'h00, d); chk("R9 status0", d, 0);
    rd(8'h01, d); chk("R9 status1", d, 0);
    rd(8'h10, d); chk("R4 enable reset", d, 0);
    rd(8'h21, d); chk("R9 ctrl reset", d, 32'h4);

    // R1 / R3 / R5: sweep every field and hop, enables off
    for (int f = 0; f < 3; f++)
      for (int h = 0; h < HOPS; h++) begin
        int idx;
        idx = f * HOPS + h;
        pulse(f, h);
        chk("R5 disabled irq", {31'b0, irq}, 0);
        for (int w = 0; w < NSW; w++) begin
          rd(8'(w), d);
          chk("R1 packing", d, (idx / 32 == w) ? (32'd1 << (idx % 32)) : 32'd0);
        end
        for (int w = 0; w < NSW; w++) begin
          rd(8'(w), d);
          chk("R3 cleared", d, 0);
        end
      end

    // R3 event in the same cycle as a clearing read
    @(negedge clk); rd_en = 1; addr = 8'h00; ev_tx[3] = 1;
    @(negedge clk); rd_en = 0; ev_tx = '0;
    chk("R3 same-cycle read data", rdata, 0);
    rd(8'h00, d); chk("R3 same-cycle event kept", d, 32'h8);

    // R4 enable readback and masking
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h10, d); chk("R4 enable mask", d, 32'h00FF_FFFF);
    wr(8'h10, 32'd1 << 2);
    rd(8'h10, d); chk("R4 enable value", d, 32'h4);

    // R5 gating: tx hop2 not enabled, overflow hop2 via receive enable
    pulse(0, 2);
    chk("R5 tx disabled", {31'b0, irq}, 0);
    rd(8'h00, d); rd(8'h01, d);
    pulse(2, 2);
    chk("R5 overflow via rx enable", {31'b0, irq}, 1);

    // R6 disarm and sweep
    rd(8'h01, d);
    chk("R6 disarm on read", {31'b0, irq}, 0);
    pulse(1, 2);
    chk("R6 held while disarmed", {31'b0, irq}, 0);
    rd(8'h01, d);
    chk("R6 repeat read no rearm", {31'b0, irq}, 0);
    rd(8'h00, d);
    chk("R1 rx2+ovf2 word", d, 32'h0400_4000);
    chk("R6 rearmed, nothing pending", {31'b0, irq}, 0);
    pulse(1, 2);
    chk("R6 fires after rearm", {31'b0, irq}, 1);
    rd(8'h00, d); chk("R3 rx2 read", d, 32'h4000);
    chk("R6 disarmed", {31'b0, irq}, 0);
    rd(8'h00, d);
    chk("R6 same word twice", {31'b0, irq}, 0);
    pulse(1, 2);
    chk("R6 still disarmed", {31'b0, irq}, 0);
    rd(8'h01, d);
    chk("R6 rearm pending rx2 fires", {31'b0, irq}, 1);
    rd(8'h00, d); rd(8'h01, d);
    chk("R6 cleared sweep", {31'b0, irq}, 0);

    // R5 transmit enable
    wr(8'h10, 32'd1 << (HOPS + 5));
    pulse(0, 5);
    chk("R5 tx enable", {31'b0, irq}, 1);
    rd(8'h00, d); chk("R1 tx5", d, 32'h20);
    rd(8'h01, d);
    chk("R6 rearm idle", {31'b0, irq}, 0);
    wr(8'h10, 32'd0);

    // R8 keep mode with write-one-to-clear
    wr(8'h21, 32'd0);
    rd(8'h21, d); chk("R8 ctrl write", d, 0);
    pulse(0, 5); pulse(0, 6);
    rd(8'h00, d); chk("R8 read keeps", d, 32'h60);
    rd(8'h00, d); chk("R8 read keeps again", d, 32'h60);
    wr(8'h00, 32'h20);
    rd(8'h00, d); chk("R8 w1c partial", d, 32'h40);
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, d); chk("R8 w1c all", d, 0);
    wr(8'h21, 32'h4);
    pulse(0, 7);
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, d); chk("R8 write ignored in read-clear mode", d, 32'h80);

    // R7 hop count, R10 unmapped
    rd(8'h20, d); chk("R7 hop count", d, HOPS);
    wr(8'h20, 32'h0);
    rd(8'h20, d); chk("R7 write ignored", d, HOPS);
    rd(8'h30, d); chk("R10 unmapped", d, 0);
    rd(8'h02, d); chk("R10 past status", d, 0);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule